// File: doc/BRIEF.md
# PWM Break and Main Output Enable Controller

This block decides, for each complementary pin pair of an advanced PWM timer, whether the pin is driven by the waveform generator, held at a programmed idle level, or left undriven (output enable low). A single main output enable bit governs the whole set. Software writes the main enable directly, an update pulse from the timer can re-arm it automatically, and an external break input can force it off at once.

A one-beat control write port carries the main enable, the automatic re-arm enable, break polarity, break enable, the two off-state selects (one for a stopped timer or disabled main enable, one for a running timer) and a per-pin idle level. A lock level input blocks writes to protected fields. The break settings pass through an extra register stage, so a change to them acts one clock after the write lands. When a pin is moved to its idle level, the level is presented first and the pin's output enable follows one clock later. The PWM waveform, dead-time insertion and the lock register itself are outside this block.

Top module: `pwm_brk_moe`

## Requirements
- R1: After reset the main enable is 0, every pin's output enable and idle select are 0, and every reported idle level is 0.
- R2: A control write sets the main enable to the written value on the next clock edge, unless a break is active on that edge.
- R3: With the re-arm bit at 1, an update pulse sets the main enable on the next edge. With the re-arm bit at 0, an update pulse leaves it unchanged.
- R4: A break is active when break enable is 1 and the break pin equals the polarity bit (1 = active high, 0 = active low). An active break drives the main enable output to 0 in the same cycle. The stored main enable is cleared on the next edge. Writes and update pulses cannot set it while the break stays active.
- R5: With break enable at 0, the break pin has no effect on the main enable.
- R6: A write to break polarity or break enable changes break detection one clock cycle after the edge that stores the write.
- R7: With lock level 1 or above, writes leave re-arm, break polarity, break enable and the idle levels unchanged, but still update the other fields. With lock level 2 or above, the two off-state selects are also left unchanged. Lock level is a 2-bit value.
- R8: With the main enable at 1 and the timer stopped, a pin whose channel enable is 1 under off-state-idle select 1 shows idle select 1 at once and output enable 1 from the following cycle. With that select at 0, the pin is disabled.
- R9: With the main enable at 1 and the timer running, a pin whose channel enable is 1 has output enable 1 and idle select 0 in the same cycle.
- R10: With the main enable at 1 and the timer running, a pin whose channel enable is 0 follows the idle-then-enable sequence when run-state select is 1, and is disabled when it is 0.
- R11: With the main enable at 0, every pin follows the idle-then-enable sequence when off-state-idle select is 1. When that select is 0, every pin has output enable 0 and idle select 0.
- R12: Each pin's reported idle level equals its stored idle-level bit. Bit i of the P and N vectors belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_moe | input | 1 | Main enable value to write |
| cfg_aoe | input | 1 | Re-arm-on-update bit to write |
| cfg_bkp | input | 1 | Break polarity to write (1 = active high) |
| cfg_bke | input | 1 | Break enable to write |
| cfg_ossi | input | 1 | Off-state-idle select to write |
| cfg_ossr | input | 1 | Run-state select to write |
| cfg_ois_p | input | NCH | Idle levels for P pins to write |
| cfg_ois_n | input | NCH | Idle levels for N pins to write |
| lock_lvl | input | 2 | Write protection level |
| brk_in | input | 1 | Break pin |
| upd_evt | input | 1 | Timer update pulse |
| tmr_run | input | 1 | Timer running flag |
| ch_en_p | input | NCH | Per-channel P pin enable |
| ch_en_n | input | NCH | Per-channel N pin enable |
| moe_o | output | 1 | Main output enable |
| oc_en_p | output | NCH | P pin output enable |
| oc_en_n | output | NCH | N pin output enable |
| oc_idle_p | output | NCH | P pin idle select (1 = drive idle level) |
| oc_idle_n | output | NCH | N pin idle select (1 = drive idle level) |
| oc_lvl_p | output | NCH | P pin idle level |
| oc_lvl_n | output | NCH | N pin idle level |

## Verification
The bench targets the one-clock lag on break settings. It writes a polarity that makes the current pin level active and checks that the main enable survives exactly one more cycle. A design without the lag drops it early, and one with two stages drops it late. It also checks the idle-then-enable order by sampling the cycle right after a pin enters idle, where an eager design shows output enable already high. The bench tries to re-set the main enable during a break by software write and by update pulse, and sweeps lock levels 1 and 2. A priority or lock decode error then shows up as a main enable that comes back, or as a protected field that changes.

// File: rtl/pwm_brk_pkg.sv
// Package: shared types and constants for the break / main-enable controller.
// Assumes: lock level is a 2-bit code where larger values protect more fields.
package pwm_brk_pkg;

    // Stored control fields that live in one register bank.
    typedef struct packed {
        logic aoe;
        logic bkp;
        logic bke;
        logic ossi;
        logic ossr;
    } ctl_t;

    // What one output pin is doing this cycle.
    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_ACTIVE = 2'd1,
        PIN_IDLE   = 2'd2
    } pin_mode_e;

    localparam logic [1:0] LOCK_L1 = 2'd1;
    localparam logic [1:0] LOCK_L2 = 2'd2;

endpackage

// File: rtl/brk_cfg_regs.sv
// Module: brk_cfg_regs
// Holds the control fields and per-pin idle levels, applying lock-level write
// protection. It also keeps a second copy of the break polarity and break
// enable, so changes to them act one clock after the write lands.
// Assumes: cfg_we is a single-cycle strobe in the clk domain.
module brk_cfg_regs
    import pwm_brk_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  ctl_t           wr_ctl,
    input  logic [NCH-1:0] wr_ois_p,
    input  logic [NCH-1:0] wr_ois_n,
    input  logic [1:0]     lock_lvl,
    output logic           aoe_q,
    output logic           ossi_q,
    output logic           ossr_q,
    output logic [NCH-1:0] ois_p_q,
    output logic [NCH-1:0] ois_n_q,
    output logic           bkp_eff,
    output logic           bke_eff
);

    ctl_t ctl_q;
    logic lock_a;
    logic lock_b;

    // Decode which groups of fields are writable at the current lock level.
    always_comb begin
        lock_a = (lock_lvl >= LOCK_L1);
        lock_b = (lock_lvl >= LOCK_L2);
    end

    // Control field bank, written under lock protection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            ois_p_q <= '0;
            ois_n_q <= '0;
        end else if (cfg_we) begin
            if (!lock_a) begin
                ctl_q.aoe <= wr_ctl.aoe;
                ctl_q.bkp <= wr_ctl.bkp;
                ctl_q.bke <= wr_ctl.bke;
                ois_p_q   <= wr_ois_p;
                ois_n_q   <= wr_ois_n;
            end
            if (!lock_b) begin
                ctl_q.ossi <= wr_ctl.ossi;
                ctl_q.ossr <= wr_ctl.ossr;
            end
        end
    end

    // Second stage for break settings: detection uses these copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bkp_eff <= 1'b0;
            bke_eff <= 1'b0;
        end else begin
            bkp_eff <= ctl_q.bkp;
            bke_eff <= ctl_q.bke;
        end
    end

    assign aoe_q  = ctl_q.aoe;
    assign ossi_q = ctl_q.ossi;
    assign ossr_q = ctl_q.ossr;

endmodule

// File: rtl/brk_moe_ctrl.sv
// Module: brk_moe_ctrl
// Detects an active break and maintains the main output enable. Priority on
// each edge: break clears, then software write, then update-pulse re-arm.
// Assumes: brk_in is already synchronous to clk.
module brk_moe_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic brk_in,
    input  logic bkp_eff,
    input  logic bke_eff,
    input  logic aoe_q,
    input  logic upd_evt,
    input  logic sw_we,
    input  logic sw_moe,
    output logic brk_act,
    output logic moe_q,
    output logic moe_o
);

    // Break is live when enabled and the pin sits at the chosen polarity.
    always_comb begin
        brk_act = bke_eff & (brk_in == bkp_eff);
    end

    // Stored main enable with break > write > re-arm priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            moe_q <= 1'b0;
        end else if (brk_act) begin
            moe_q <= 1'b0;
        end else if (sw_we) begin
            moe_q <= sw_moe;
        end else if (aoe_q && upd_evt) begin
            moe_q <= 1'b1;
        end
    end

    // Output masks the stored bit at once while a break is live.
    always_comb begin
        moe_o = moe_q & ~brk_act;
    end

endmodule

// File: rtl/brk_pin_seq.sv
// Module: brk_pin_seq
// Chooses the state of a single output pin and sequences entry into the idle
// state: the idle select rises first, and the enable follows one clock later.
// Assumes: all inputs are synchronous to clk.
module brk_pin_seq
    import pwm_brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic moe,
    input  logic tmr_run,
    input  logic ch_en,
    input  logic ossi,
    input  logic ossr,
    output logic pin_en,
    output logic pin_idle
);

    pin_mode_e mode;
    logic      idle_req;
    logic      idle_seen_q;

    // Pick the pin mode from main enable, timer state and off-state selects.
    always_comb begin
        if (!moe) begin
            mode = ossi ? PIN_IDLE : PIN_OFF;
        end else if (!tmr_run) begin
            mode = (ch_en && ossi) ? PIN_IDLE : PIN_OFF;
        end else if (ch_en) begin
            mode = PIN_ACTIVE;
        end else begin
            mode = ossr ? PIN_IDLE : PIN_OFF;
        end
        idle_req = (mode == PIN_IDLE);
    end

    // Remember that idle was requested last cycle, to delay the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_seen_q <= 1'b0;
        end else begin
            idle_seen_q <= idle_req;
        end
    end

    // Drive the pin outputs.
    always_comb begin
        pin_idle = idle_req;
        pin_en   = (mode == PIN_ACTIVE) | (idle_req & idle_seen_q);
    end

endmodule

// File: rtl/pwm_brk_moe.sv
// Module: pwm_brk_moe (top)
// Break and main-output-enable controller for NCH complementary pin pairs.
// Ties the control bank, the main-enable logic and one pin sequencer per pin.
// Assumes: synchronous inputs, synchronous active-low reset.
module pwm_brk_moe
    import pwm_brk_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_moe,
    input  logic           cfg_aoe,
    input  logic           cfg_bkp,
    input  logic           cfg_bke,
    input  logic           cfg_ossi,
    input  logic           cfg_ossr,
    input  logic [NCH-1:0] cfg_ois_p,
    input  logic [NCH-1:0] cfg_ois_n,
    input  logic [1:0]     lock_lvl,
    input  logic           brk_in,
    input  logic           upd_evt,
    input  logic           tmr_run,
    input  logic [NCH-1:0] ch_en_p,
    input  logic [NCH-1:0] ch_en_n,
    output logic           moe_o,
    output logic [NCH-1:0] oc_en_p,
    output logic [NCH-1:0] oc_en_n,
    output logic [NCH-1:0] oc_idle_p,
    output logic [NCH-1:0] oc_idle_n,
    output logic [NCH-1:0] oc_lvl_p,
    output logic [NCH-1:0] oc_lvl_n
);

    ctl_t wr_ctl;
    logic aoe_q;
    logic ossi_q;
    logic ossr_q;
    logic bkp_eff;
    logic bke_eff;
    logic brk_act;
    logic moe_q;

    // Pack the write-port fields for the register bank.
    always_comb begin
        wr_ctl.aoe  = cfg_aoe;
        wr_ctl.bkp  = cfg_bkp;
        wr_ctl.bke  = cfg_bke;
        wr_ctl.ossi = cfg_ossi;
        wr_ctl.ossr = cfg_ossr;
    end

    brk_cfg_regs #(.NCH(NCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .wr_ctl   (wr_ctl),
        .wr_ois_p (cfg_ois_p),
        .wr_ois_n (cfg_ois_n),
        .lock_lvl (lock_lvl),
        .aoe_q    (aoe_q),
        .ossi_q   (ossi_q),
        .ossr_q   (ossr_q),
        .ois_p_q  (oc_lvl_p),
        .ois_n_q  (oc_lvl_n),
        .bkp_eff  (bkp_eff),
        .bke_eff  (bke_eff)
    );

    brk_moe_ctrl u_moe (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_in  (brk_in),
        .bkp_eff (bkp_eff),
        .bke_eff (bke_eff),
        .aoe_q   (aoe_q),
        .upd_evt (upd_evt),
        .sw_we   (cfg_we),
        .sw_moe  (cfg_moe),
        .brk_act (brk_act),
        .moe_q   (moe_q),
        .moe_o   (moe_o)
    );

    // One sequencer per pin: P and N side of each channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        brk_pin_seq u_pin_p (
            .clk      (clk),
            .rst_n    (rst_n),
            .moe      (moe_o),
            .tmr_run  (tmr_run),
            .ch_en    (ch_en_p[ch]),
            .ossi     (ossi_q),
            .ossr     (ossr_q),
            .pin_en   (oc_en_p[ch]),
            .pin_idle (oc_idle_p[ch])
        );
        brk_pin_seq u_pin_n (
            .clk      (clk),
            .rst_n    (rst_n),
            .moe      (moe_o),
            .tmr_run  (tmr_run),
            .ch_en    (ch_en_n[ch]),
            .ossi     (ossi_q),
            .ossr     (ossr_q),
            .pin_en   (oc_en_n[ch]),
            .pin_idle (oc_idle_n[ch])
        );
    end

endmodule

// File: rtl/pwm_brk_moe_chk.sv
// Module: pwm_brk_moe_chk
// Property checker for pwm_brk_moe, attached through bind below.
// Assumes: sampled on the rising clock edge, idle while reset is low.
module pwm_brk_moe_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic           cfg_moe,
    input logic [1:0]     lock_lvl,
    input logic           tmr_run,
    input logic [NCH-1:0] ch_en_p,
    input logic           brk_act,
    input logic           moe_q,
    input logic           moe_o,
    input logic           aoe_q,
    input logic           ossi_q,
    input logic [NCH-1:0] oc_en_p,
    input logic [NCH-1:0] oc_en_n,
    input logic [NCH-1:0] oc_idle_p,
    input logic [NCH-1:0] oc_idle_n
);

    AST_SW_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_moe && !brk_act) |=> moe_q); // R2

    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !aoe_q && !moe_q) |=> !moe_q); // R3

    AST_BREAK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_act |=> !moe_q); // R4

    AST_LOCK_KEEPS_AOE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && lock_lvl != 2'd0) |=> $stable(aoe_q)); // R7

    AST_IDLE_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ((oc_en_p & oc_idle_p & ~$past(oc_idle_p)) == '0)); // R8

    AST_RUN_DRIVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (moe_o && tmr_run) |-> ((ch_en_p & ~(oc_en_p & ~oc_idle_p)) == '0)); // R9

    AST_OFF_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!moe_o && !ossi_q) |-> ((oc_en_p | oc_en_n | oc_idle_p | oc_idle_n) == '0)); // R11

endmodule

bind pwm_brk_moe pwm_brk_moe_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_moe   (cfg_moe),
    .lock_lvl  (lock_lvl),
    .tmr_run   (tmr_run),
    .ch_en_p   (ch_en_p),
    .brk_act   (brk_act),
    .moe_q     (moe_q),
    .moe_o     (moe_o),
    .aoe_q     (aoe_q),
    .ossi_q    (ossi_q),
    .oc_en_p   (oc_en_p),
    .oc_en_n   (oc_en_n),
    .oc_idle_p (oc_idle_p),
    .oc_idle_n (oc_idle_n)
);

// File: tb/pwm_brk_moe_bench.sv
// Scoreboard bench for pwm_brk_moe: driver tasks queue expected values and a
// monitor process pops and compares them against the outputs.
module pwm_brk_moe_bench;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0, cfg_moe = 1'b0, cfg_aoe = 1'b0, cfg_bkp = 1'b0;
    logic           cfg_bke = 1'b0, cfg_ossi = 1'b0, cfg_ossr = 1'b0;
    logic [NCH-1:0] cfg_ois_p = '0, cfg_ois_n = '0;
    logic [1:0]     lock_lvl = 2'd0;
    logic           brk_in = 1'b0, upd_evt = 1'b0, tmr_run = 1'b0;
    logic [NCH-1:0] ch_en_p = '0, ch_en_n = '0;
    logic           moe_o;
    logic [NCH-1:0] oc_en_p, oc_en_n, oc_idle_p, oc_idle_n, oc_lvl_p, oc_lvl_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    localparam int S_MOE = 0, S_ENP = 1, S_ENN = 2, S_IDP = 3, S_IDN = 4, S_LVP = 5, S_LVN = 6;

    always #4 clk = ~clk;

    pwm_brk_moe #(.NCH(NCH)) u_pwm_brk_moe (.*);

    function automatic logic [31:0] probe(int sel);
        case (sel)
            S_MOE:   return {31'd0, moe_o};
            S_ENP:   return 32'(oc_en_p);
            S_ENN:   return 32'(oc_en_n);
            S_IDP:   return 32'(oc_idle_p);
            S_IDN:   return 32'(oc_idle_n);
            S_LVP:   return 32'(oc_lvl_p);
            default: return 32'(oc_lvl_n);
        endcase
    endfunction

    // Monitor: pop each queued expectation and compare.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = q.pop_front();
                act = probe(it.sel);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(string req, int sel, logic [31:0] v);
        q.push_back('{req, sel, v});
    endtask

    task automatic flush();
        #1;
        ->chk_ev;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic m, a, bp, bk, si, sr, input logic [NCH-1:0] ip, in_);
        @(negedge clk);
        cfg_we = 1'b1; cfg_moe = m; cfg_aoe = a; cfg_bkp = bp; cfg_bke = bk;
        cfg_ossi = si; cfg_ossr = sr; cfg_ois_p = ip; cfg_ois_n = in_;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk);
        upd_evt = 1'b1;
        @(negedge clk);
        upd_evt = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        flush();
        // R1 reset state
        expect_v("R1", S_MOE, 0); expect_v("R1", S_ENP, 0); expect_v("R1", S_ENN, 0);
        expect_v("R1", S_IDP, 0); expect_v("R1", S_LVP, 0);
        flush();

        // R2 software write sets and clears
        wr(1, 0, 0, 0, 0, 0, 4'h0, 4'h0);
        expect_v("R2", S_MOE, 1); expect_v("R8", S_ENP, 0); flush();
        wr(0, 0, 0, 0, 0, 0, 4'h0, 4'h0);
        expect_v("R2", S_MOE, 0); flush();

        // R3 update pulse with re-arm off, then on
        pulse_upd();
        expect_v("R3", S_MOE, 0); flush();
        wr(0, 1, 0, 0, 0, 0, 4'h0, 4'h0);
        pulse_upd();
        expect_v("R3", S_MOE, 1); flush();

        // R11 / R12 main enable off, off-state idle on
        wr(0, 0, 0, 0, 1, 0, 4'hA, 4'h5);
        expect_v("R11", S_IDP, 4'hF); expect_v("R11", S_ENP, 0);
        expect_v("R12", S_LVP, 4'hA); expect_v("R12", S_LVN, 4'h5); flush();
        step();
        expect_v("R11", S_ENP, 4'hF); expect_v("R11", S_ENN, 4'hF); flush();
        wr(0, 0, 0, 0, 0, 0, 4'hA, 4'h5);
        expect_v("R11", S_ENP, 0); expect_v("R11", S_IDN, 0); flush();

        // R8 timer stopped, main enable on
        ch_en_p = 4'h3; ch_en_n = 4'h1; tmr_run = 1'b0;
        wr(1, 0, 0, 0, 1, 0, 4'hA, 4'h5);
        expect_v("R8", S_IDP, 4'h3); expect_v("R8", S_ENP, 0); expect_v("R8", S_IDN, 4'h1); flush();
        step();
        expect_v("R8", S_ENP, 4'h3); expect_v("R8", S_ENN, 4'h1); flush();
        wr(1, 0, 0, 0, 0, 0, 4'hA, 4'h5);
        expect_v("R8", S_ENP, 0); expect_v("R8", S_IDP, 0); flush();

        // R9 / R10 timer running
        @(negedge clk); tmr_run = 1'b1;
        flush();
        expect_v("R9", S_ENP, 4'h3); expect_v("R9", S_IDP, 0); expect_v("R10", S_ENN, 4'h1); flush();
        wr(1, 0, 0, 0, 0, 1, 4'hA, 4'h5);
        expect_v("R10", S_IDP, 4'hC); expect_v("R10", S_ENP, 4'h3); expect_v("R10", S_IDN, 4'hE); flush();
        step();
        expect_v("R10", S_ENP, 4'hF); expect_v("R10", S_ENN, 4'hF); flush();

        // R4 / R6 active-high break
        tmr_run = 1'b0; ch_en_p = '0; ch_en_n = '0; brk_in = 1'b1;
        wr(1, 0, 1, 1, 0, 0, 4'hA, 4'h5);
        expect_v("R6", S_MOE, 1); flush();
        step();
        expect_v("R6", S_MOE, 0); flush();
        wr(1, 1, 1, 1, 0, 0, 4'hA, 4'h5);
        expect_v("R4", S_MOE, 0); flush();
        pulse_upd();
        expect_v("R4", S_MOE, 0); flush();
        @(negedge clk); brk_in = 1'b0;
        flush();
        expect_v("R4", S_MOE, 0); flush();
        pulse_upd();
        expect_v("R3", S_MOE, 1); flush();

        // R6 / R4 active-low break
        wr(1, 0, 0, 1, 0, 0, 4'hA, 4'h5);
        expect_v("R6", S_MOE, 1); flush();
        step();
        expect_v("R6", S_MOE, 0); flush();
        @(negedge clk); brk_in = 1'b1;
        wr(1, 0, 0, 1, 0, 0, 4'hA, 4'h5);
        expect_v("R4", S_MOE, 1); flush();
        @(negedge clk); brk_in = 1'b0;
        flush();
        expect_v("R4", S_MOE, 0); flush();

        // R5 break disabled
        wr(1, 0, 0, 0, 0, 0, 4'hA, 4'h5);
        wr(1, 0, 0, 0, 0, 0, 4'hA, 4'h5);
        expect_v("R5", S_MOE, 1); flush();
        @(negedge clk); brk_in = 1'b1;
        step(); brk_in = 1'b0;
        step();
        expect_v("R5", S_MOE, 1); flush();

        // R7 lock level 1
        lock_lvl = 2'd1; brk_in = 1'b1;
        wr(1, 1, 1, 1, 1, 0, 4'hF, 4'hF);
        step(); step();
        expect_v("R7", S_MOE, 1); expect_v("R7", S_LVP, 4'hA); expect_v("R7", S_LVN, 4'h5); flush();
        wr(0, 0, 1, 1, 1, 0, 4'hF, 4'hF);
        expect_v("R7", S_IDP, 4'hF); flush();
        pulse_upd();
        expect_v("R7", S_MOE, 0); flush();
        // R7 lock level 2
        lock_lvl = 2'd2;
        wr(0, 0, 0, 0, 0, 0, 4'h0, 4'h0);
        expect_v("R7", S_IDP, 4'hF); expect_v("R7", S_LVP, 4'hA); flush();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule